// File: doc/BRIEF.md
# Status-Change and Interrupt Flag Arbiter

This block holds two host-visible request flags: a status-change request and an interrupt request. Each is set by an event on the subsystem side and cleared by an event on the host side. A subsystem write into attribute memory sets the status-change flag, but only while the status-change enable (bit 2 of the subsystem control register, wired to `stsEnable`) is 1. Any host read of attribute memory clears that flag. The interrupt flag has its own set and clear strobes and is arbitrated the same way.

All four event strobes can arrive asynchronously. Each one passes through a synchronizer and a rising-edge detector into the free-running arbitration clock domain. The flags change only on that clock, so the active-low outputs cannot pulse falsely. When a set and a clear fall in the same arbitration cycle, the set wins. When a clear lands in a later arbitration cycle than the set, the flag ends cleared.

Top module: `scArbiter`

## Requirements
- R1: While `rstN` is low, and right after it is released, `statusChgN` and `irqN` are both 1 (deasserted).
- R2: Both outputs are active-low: a set flag drives its output to 0, and a cleared flag drives it to 1.
- R3: A rising edge on `subWrStrb` while `stsEnable` is 1 drives `statusChgN` low.
- R4: A rising edge on `subWrStrb` while `stsEnable` is 0 leaves `statusChgN` unchanged.
- R5: A rising edge on `hostRdStrb` drives `statusChgN` high, whatever the value of `stsEnable`.
- R6: When rising edges on `subWrStrb` (enabled) and `hostRdStrb` occur together, `statusChgN` ends low.
- R7: When `hostRdStrb` rises one or more arbitration cycles after an enabled `subWrStrb` edge, `statusChgN` first goes low and then ends high.
- R8: A rising edge on `irqSetStrb` drives `irqN` low, and a rising edge on `irqClrStrb` drives it high. When both rise together, `irqN` ends low.
- R9: Each strobe acts once, on its rising edge only. A strobe held high does not block a later opposing event.
- R10: A strobe that rises before arbitration edge k changes its output just after edge k+2 and not earlier, because of two synchronizer stages and one flag register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| arbClk | input | 1 | Free-running arbitration clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stsEnable | input | 1 | Status-change enable, bit 2 of the subsystem control register |
| subWrStrb | input | 1 | Subsystem attribute-memory write strobe, active high |
| hostRdStrb | input | 1 | Host attribute-memory read strobe, active high |
| irqSetStrb | input | 1 | Interrupt set strobe, active high |
| irqClrStrb | input | 1 | Interrupt clear strobe, active high |
| statusChgN | output | 1 | Status-change request, active low |
| irqN | output | 1 | Interrupt request, active low |

## Verification
The assertions assume the following about the inputs:
- Every strobe stays high for at least one full arbitration cycle, and stays low for at least one cycle between events.
- `stsEnable` holds steady around each write edge, because it is sampled directly without a synchronizer.

The bench keeps to these assumptions:
- It drives all inputs on the falling clock edge.
- It holds each random strobe pulse for one full cycle and then leaves several idle cycles.
- It changes `stsEnable` only while the strobes are low.
- It sets up coincident events by raising both strobes at the same falling edge, and staggered events by raising them whole cycles apart.

// File: rtl/sc_arb_pkg.sv
package sc_arb_pkg;
  localparam int NUM_EVENTS = 4;

  // Event strobe order inside the synchronizer vector
  localparam int EV_STS_SET = 0;
  localparam int EV_STS_CLR = 1;
  localparam int EV_IRQ_SET = 2;
  localparam int EV_IRQ_CLR = 3;

  localparam int NUM_FLAGS = 2;
  localparam int FLAG_STS  = 0;
  localparam int FLAG_IRQ  = 1;

  typedef struct packed {
    logic [NUM_FLAGS-1:0] setReq;
    logic [NUM_FLAGS-1:0] clrReq;
  } arbStrobes_t;
endpackage

// File: rtl/sc_arb_ctrl.sv
module sc_arb_ctrl
  import sc_arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  arbClk,
  input  logic                  rstN,
  input  logic                  stsEnable,
  input  logic [NUM_EVENTS-1:0] rawEvents,
  output arbStrobes_t           strobes
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [NUM_EVENTS-1:0] edgePulse;

  for (genvar g = 0; g < NUM_EVENTS; g++) begin : g_sync
    logic [CHAIN_W-1:0] chain;

    always_ff @(posedge arbClk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[CHAIN_W-2:0], rawEvents[g]};
    end

    // Rising edge seen after the last synchronizer stage
    assign edgePulse[g] = chain[CHAIN_W-2] & ~chain[CHAIN_W-1];

    a_r9_single_pulse: assert property (@(posedge arbClk) disable iff (!rstN)
      edgePulse[g] |=> !edgePulse[g]);
  end

  always_comb begin
    strobes = '0;
    strobes.setReq[FLAG_STS] = edgePulse[EV_STS_SET] & stsEnable;
    strobes.clrReq[FLAG_STS] = edgePulse[EV_STS_CLR];
    strobes.setReq[FLAG_IRQ] = edgePulse[EV_IRQ_SET];
    strobes.clrReq[FLAG_IRQ] = edgePulse[EV_IRQ_CLR];
  end

  a_r4_disabled_write_masked: assert property (@(posedge arbClk) disable iff (!rstN)
    !stsEnable |-> !strobes.setReq[FLAG_STS]);
endmodule

// File: rtl/sc_arb_flags.sv
module sc_arb_flags
  import sc_arb_pkg::*;
(
  input  logic                 arbClk,
  input  logic                 rstN,
  input  arbStrobes_t          strobes,
  output logic [NUM_FLAGS-1:0] flags
);
  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    always_ff @(posedge arbClk or negedge rstN) begin
      if (!rstN)                  flags[g] <= 1'b0;
      else if (strobes.setReq[g]) flags[g] <= 1'b1;  // set has priority
      else if (strobes.clrReq[g]) flags[g] <= 1'b0;
    end

    a_r6_set_wins: assert property (@(posedge arbClk) disable iff (!rstN)
      strobes.setReq[g] |=> flags[g]);
    a_r5_clear_takes: assert property (@(posedge arbClk) disable iff (!rstN)
      (strobes.clrReq[g] && !strobes.setReq[g]) |=> !flags[g]);
    a_r9_idle_holds: assert property (@(posedge arbClk) disable iff (!rstN)
      (!strobes.clrReq[g] && !strobes.setReq[g]) |=> $stable(flags[g]));
  end
endmodule

// File: rtl/scArbiter.sv
module scArbiter
  import sc_arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic arbClk,
  input  logic rstN,
  input  logic stsEnable,
  input  logic subWrStrb,
  input  logic hostRdStrb,
  input  logic irqSetStrb,
  input  logic irqClrStrb,
  output logic statusChgN,
  output logic irqN
);
  logic [NUM_EVENTS-1:0] rawEvents;
  arbStrobes_t           strobes;
  logic [NUM_FLAGS-1:0]  flags;

  always_comb begin
    rawEvents             = '0;
    rawEvents[EV_STS_SET] = subWrStrb;
    rawEvents[EV_STS_CLR] = hostRdStrb;
    rawEvents[EV_IRQ_SET] = irqSetStrb;
    rawEvents[EV_IRQ_CLR] = irqClrStrb;
  end

  sc_arb_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .arbClk   (arbClk),
    .rstN     (rstN),
    .stsEnable(stsEnable),
    .rawEvents(rawEvents),
    .strobes  (strobes)
  );

  sc_arb_flags i_flags (
    .arbClk (arbClk),
    .rstN   (rstN),
    .strobes(strobes),
    .flags  (flags)
  );

  assign statusChgN = ~flags[FLAG_STS];
  assign irqN       = ~flags[FLAG_IRQ];

  a_r1_reset_idle: assert property (@(posedge arbClk)
    !rstN |=> (statusChgN && irqN));
endmodule

// File: tb/test_scArbiter.sv
module test_scArbiter;
  logic arbClk = 1'b0;
  logic rstN = 1'b0;
  logic stsEnable = 1'b0;
  logic subWrStrb = 1'b0;
  logic hostRdStrb = 1'b0;
  logic irqSetStrb = 1'b0;
  logic irqClrStrb = 1'b0;
  logic statusChgN;
  logic irqN;

  int checks = 0;
  int fails = 0;
  bit stsExp = 1'b0;  // 1 = asserted
  bit irqExp = 1'b0;

  always #4 arbClk = ~arbClk;  // 125 MHz

  scArbiter i_scArbiter (
    .arbClk(arbClk), .rstN(rstN), .stsEnable(stsEnable),
    .subWrStrb(subWrStrb), .hostRdStrb(hostRdStrb),
    .irqSetStrb(irqSetStrb), .irqClrStrb(irqClrStrb),
    .statusChgN(statusChgN), .irqN(irqN)
  );

  function automatic bit nextFlag(bit cur, bit setEv, bit clrEv);
    if (setEv) return 1'b1;
    if (clrEv) return 1'b0;
    return cur;
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) @(negedge arbClk);
  endtask

  task automatic checkBoth(string req);
    check(req, statusChgN, !stsExp);
    check(req, irqN, !irqExp);
  endtask

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    ticks(3);
    check("R1 in reset", statusChgN, 1'b1);
    check("R1 in reset", irqN, 1'b1);
    rstN = 1'b1;
    ticks(2);
    check("R1 after release", statusChgN, 1'b1);
    check("R1 after release", irqN, 1'b1);

    // R10 latency: rise at negedge, edges 1,2 sync, edge 3 flag
    stsEnable = 1'b1;
    subWrStrb = 1'b1;
    ticks(1);
    subWrStrb = 1'b0;
    ticks(1);
    check("R10 not early", statusChgN, 1'b1);
    ticks(1);
    check("R10/R3 asserted on third edge", statusChgN, 1'b0);
    stsExp = 1'b1;

    // R5 clear while disabled
    stsEnable = 1'b0;
    hostRdStrb = 1'b1;
    ticks(1);
    hostRdStrb = 1'b0;
    ticks(4);
    stsExp = 1'b0;
    check("R5 read clears with enable 0", statusChgN, 1'b1);

    // R4 write with enable 0 ignored
    subWrStrb = 1'b1;
    ticks(1);
    subWrStrb = 1'b0;
    ticks(4);
    check("R4 disabled write ignored", statusChgN, 1'b1);

    // R6 coincident write and read
    stsEnable = 1'b1;
    subWrStrb = 1'b1;
    hostRdStrb = 1'b1;
    ticks(1);
    subWrStrb = 1'b0;
    hostRdStrb = 1'b0;
    ticks(4);
    stsExp = 1'b1;
    check("R6 coincident write wins", statusChgN, 1'b0);

    // R7 staggered: clear first, then write, then read a cycle later
    hostRdStrb = 1'b1;
    ticks(1);
    hostRdStrb = 1'b0;
    ticks(4);
    subWrStrb = 1'b1;
    ticks(1);
    subWrStrb = 1'b0;
    hostRdStrb = 1'b1;
    ticks(1);
    hostRdStrb = 1'b0;
    ticks(1);
    check("R7 asserted before late read", statusChgN, 1'b0);
    ticks(1);
    check("R7 late read ends deasserted", statusChgN, 1'b1);
    stsExp = 1'b0;
    ticks(3);

    // R9 write held high, read still clears
    subWrStrb = 1'b1;
    ticks(4);
    check("R9 held write asserts", statusChgN, 1'b0);
    hostRdStrb = 1'b1;
    ticks(1);
    hostRdStrb = 1'b0;
    ticks(4);
    check("R9 read clears during held write", statusChgN, 1'b1);
    subWrStrb = 1'b0;
    ticks(4);

    // R8 irq set, clear, coincident
    irqSetStrb = 1'b1;
    ticks(1);
    irqSetStrb = 1'b0;
    ticks(4);
    check("R8 irq set", irqN, 1'b0);
    check("R2 irq active low", statusChgN, 1'b1);
    irqClrStrb = 1'b1;
    ticks(1);
    irqClrStrb = 1'b0;
    ticks(4);
    check("R8 irq clear", irqN, 1'b1);
    irqSetStrb = 1'b1;
    irqClrStrb = 1'b1;
    ticks(1);
    irqSetStrb = 1'b0;
    irqClrStrb = 1'b0;
    ticks(4);
    irqExp = 1'b1;
    check("R8 irq coincident set wins", irqN, 1'b0);

    // Random transactions (R2 R3 R4 R5 R6 R8)
    for (int it = 0; it < 300; it++) begin
      bit w, r, e, s, c;
      w = 1'($urandom_range(0, 1));
      r = 1'($urandom_range(0, 1));
      e = 1'($urandom_range(0, 1));
      s = 1'($urandom_range(0, 1));
      c = 1'($urandom_range(0, 1));
      stsEnable = e;
      ticks(1);
      subWrStrb = w;
      hostRdStrb = r;
      irqSetStrb = s;
      irqClrStrb = c;
      ticks(1);
      subWrStrb = 1'b0;
      hostRdStrb = 1'b0;
      irqSetStrb = 1'b0;
      irqClrStrb = 1'b0;
      ticks(4);
      stsExp = nextFlag(stsExp, w && e, r);
      irqExp = nextFlag(irqExp, s, c);
      checkBoth("R2/R3/R4/R5/R6/R8 random");
    end

    // R1 reset mid-operation
    rstN = 1'b0;
    ticks(1);
    check("R1 reset clears status", statusChgN, 1'b1);
    check("R1 reset clears irq", irqN, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule